// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Read Cache

This block is a one-way (direct-mapped) read cache for a processor load path. It selects the set using only the low bits of the virtual address, which are not translated. The array can therefore be read in the same cycle the request arrives, while a separate translation buffer turns the virtual page into a physical page. One step later the translation buffer supplies the physical page number. The cache compares the tag it stored, which is a physical line address, against the translated address and reports a hit. A miss makes it fetch the whole line from a plain word-wide memory port.

Because the tag is physical, two virtual pages that map to the same physical page find the same line, so aliases never hold stale copies of each other. A parameter check rejects any configuration in which one way is larger than a page, since index bits would then need translation. When the translation buffer has not yet delivered a page number, the access stalls until one arrives. A flush input invalidates every line.

Top module: `vipt_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, `resp_valid` is 0 and `mem_req` is 0, so the first access to any set misses.
- R2: The set is virtual address bits [LINE_W+IDX_W-1:LINE_W] and the word within the line is bits [LINE_W-1:2]. A fill reads physical words {page number, virtual bits [PAGE_W-1:LINE_W], word, 2'b00} in order from word 0 to the last word.
- R3: On a hit, `resp_valid` is 1 for one cycle in the cycle after the one where `tlb_valid` is 1, and the hit issues no memory request.
- R4: An access hits only when the set is valid and its stored tag equals the physical address bits from bit LINE_W+IDX_W upward ({page number, virtual bits [PAGE_W-1:LINE_W+IDX_W]}). A hit returns the stored word of the requested physical address.
- R5: Two different virtual pages with the same page offset that translate to the same physical page hit the same line.
- R6: On a miss, `mem_req` stays high with `mem_addr` stable until each `mem_ack`. Exactly 2^(LINE_W-2) words are taken. `resp_valid` rises only in the cycle after the last word is accepted, and it carries the memory word of the requested address.
- R7: A completed fill leaves the set valid with the new tag. A repeat access to the same line then hits, and the previous occupant of that set misses.
- R8: While `tlb_valid` is 0 after a request has been accepted, `resp_valid`, `mem_req` and `req_ready` stay 0.
- R9: A flush seen while idle invalidates all lines in one cycle. A flush that arrives during an access takes effect right after that access responds, and `req_ready` is 0 until it has been applied.
- R10: From the acceptance of a request until its response, `req_ready` is 0, and no two responses fall in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all lines |
| req_valid | input | 1 | Load request present |
| req_vaddr | input | VA_W | Virtual byte address of the load |
| req_ready | output | 1 | Cache can accept a request this cycle |
| tlb_valid | input | 1 | Translated page number is present |
| tlb_ppn | input | PA_W-PAGE_W | Physical page number from the translation buffer |
| resp_valid | output | 1 | Load data valid (one cycle) |
| resp_data | output | 32 | Load data word |
| mem_req | output | 1 | Fill word request |
| mem_addr | output | PA_W | Physical byte address of the fill word |
| mem_ack | input | 1 | Memory returns the requested word |
| mem_rdata | input | 32 | Fill word data |

## Verification
The bench builds the cache with a 20-bit physical space, 16-byte lines and 16 sets, so one way is 256 bytes within a 4 KB page. That keeps four physical-address bits above the index inside the page offset. Random page numbers come from a set of three and set numbers from a set of four, so hits, conflict evictions, and lines that differ only in the untranslated tag bits all occur often. Alias pairs, stalls of several cycles, a flush during a fill and memory acknowledgements with random gaps are driven as directed cases.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_FILL   = 2'd2
  } vipt_state_e;
endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             clr_all,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]  valid_q;
  logic [TAG_W-1:0] tag_mem [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (clr_all) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];

  // R9: a flush leaves no valid line behind
  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (valid_q == '0));

  // R7: a written set reads back as valid
  assert_fill_sets_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_all) |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store #(
  parameter int IDX_W  = 4,
  parameter int WSEL_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = 1 << (IDX_W + WSEL_W);

  logic [DATA_W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) words[{wr_idx, wr_word}] <= wr_data;
  end

  assign rd_data = words[{rd_idx, rd_word}];
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int PAGE_W = 12,
  parameter int LINE_W = 4,
  parameter int IDX_W  = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   req_valid,
  input  logic [VA_W-1:0]        req_vaddr,
  output logic                   req_ready,
  input  logic                   tlb_valid,
  input  logic [PA_W-PAGE_W-1:0] tlb_ppn,
  output logic                   resp_valid,
  output logic [31:0]            resp_data,
  output logic                   mem_req,
  output logic [PA_W-1:0]        mem_addr,
  input  logic                   mem_ack,
  input  logic [31:0]            mem_rdata
);
  import vipt_pkg::*;

  localparam int PPN_W  = PA_W - PAGE_W;
  localparam int WSEL_W = LINE_W - 2;
  localparam int WORDS  = 1 << WSEL_W;
  localparam int TAG_W  = PA_W - IDX_W - LINE_W;
  localparam int WO_W   = PAGE_W - 2;
  localparam int TSHIFT = IDX_W + LINE_W - 2;

  generate
    if (IDX_W + LINE_W > PAGE_W || LINE_W < 3) begin : g_bad_geometry
      $error("vipt_cache: one way must fit in a page and a line must hold two words");
    end
  endgenerate

  // Address arithmetic on the word offset within the page
  function automatic logic [IDX_W-1:0] idx_of(input logic [WO_W-1:0] wo);
    return wo[LINE_W-2 +: IDX_W];
  endfunction

  function automatic logic [WSEL_W-1:0] wsel_of(input logic [WO_W-1:0] wo);
    return wo[0 +: WSEL_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [PPN_W-1:0] ppn,
                                              input logic [WO_W-1:0]  wo);
    logic [PA_W-3:0] wide;
    wide = {ppn, wo};
    return TAG_W'(wide >> TSHIFT);
  endfunction

  function automatic logic [PA_W-1:0] fill_addr(input logic [PPN_W-1:0]  ppn,
                                                input logic [WO_W-1:0]   wo,
                                                input logic [WSEL_W-1:0] w);
    return {ppn, wo[WO_W-1:WSEL_W], w, 2'b00};
  endfunction

  vipt_state_e state_q;
  logic [WO_W-1:0]   wo_q;
  logic [PPN_W-1:0]  ppn_q;
  logic              rd_valid_q;
  logic [TAG_W-1:0]  rd_tag_q;
  logic [31:0]       rd_word_q;
  logic [WSEL_W-1:0] cnt_q;
  logic [31:0]       hold_q;
  logic              flush_pend_q;
  logic              resp_valid_q;
  logic [31:0]       resp_data_q;

  logic [WO_W-1:0] req_wo;
  logic            unused_addr_bits;
  assign req_wo           = req_vaddr[PAGE_W-1:2];
  assign unused_addr_bits = ^{req_vaddr[VA_W-1:PAGE_W], req_vaddr[1:0]};

  // Named events
  logic flush_go, accept, stall_evt, tag_match, lookup_hit, lookup_miss;
  logic fill_ack, fill_last, want_now;

  assign flush_go    = (state_q == ST_IDLE) && (flush || flush_pend_q);
  assign req_ready   = (state_q == ST_IDLE) && !flush && !flush_pend_q;
  assign accept      = req_valid && req_ready;
  assign stall_evt   = (state_q == ST_LOOKUP) && !tlb_valid;
  assign tag_match   = rd_valid_q && (rd_tag_q == tag_of(tlb_ppn, wo_q));
  assign lookup_hit  = (state_q == ST_LOOKUP) && tlb_valid && tag_match;
  assign lookup_miss = (state_q == ST_LOOKUP) && tlb_valid && !tag_match;
  assign fill_ack    = (state_q == ST_FILL) && mem_ack;
  assign fill_last   = fill_ack && (cnt_q == WSEL_W'(WORDS - 1));
  assign want_now    = (cnt_q == wsel_of(wo_q));

  // Arrays, read with the untranslated offset in the request cycle
  logic             arr_valid;
  logic [TAG_W-1:0] arr_tag;
  logic [31:0]      arr_word;

  vipt_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (idx_of(req_wo)),
    .rd_valid (arr_valid),
    .rd_tag   (arr_tag),
    .clr_all  (flush_go),
    .wr_en    (fill_last),
    .wr_idx   (idx_of(wo_q)),
    .wr_tag   (tag_of(ppn_q, wo_q))
  );

  vipt_data_store #(.IDX_W(IDX_W), .WSEL_W(WSEL_W), .DATA_W(32)) u_data (
    .clk     (clk),
    .rd_idx  (idx_of(req_wo)),
    .rd_word (wsel_of(req_wo)),
    .rd_data (arr_word),
    .wr_en   (fill_ack),
    .wr_idx  (idx_of(wo_q)),
    .wr_word (cnt_q),
    .wr_data (mem_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      wo_q         <= '0;
      ppn_q        <= '0;
      rd_valid_q   <= 1'b0;
      rd_tag_q     <= '0;
      rd_word_q    <= '0;
      cnt_q        <= '0;
      hold_q       <= '0;
      flush_pend_q <= 1'b0;
      resp_valid_q <= 1'b0;
      resp_data_q  <= '0;
    end else begin
      resp_valid_q <= 1'b0;
      if (flush_go)   flush_pend_q <= 1'b0;
      else if (flush) flush_pend_q <= 1'b1;

      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            wo_q       <= req_wo;
            rd_valid_q <= arr_valid;
            rd_tag_q   <= arr_tag;
            rd_word_q  <= arr_word;
            state_q    <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (lookup_hit) begin
            resp_valid_q <= 1'b1;
            resp_data_q  <= rd_word_q;
            state_q      <= ST_IDLE;
          end else if (lookup_miss) begin
            ppn_q   <= tlb_ppn;
            cnt_q   <= '0;
            state_q <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (fill_ack) begin
            cnt_q <= cnt_q + 1'b1;
            if (want_now) hold_q <= mem_rdata;
            if (fill_last) begin
              resp_valid_q <= 1'b1;
              resp_data_q  <= want_now ? mem_rdata : hold_q;
              state_q      <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign resp_valid = resp_valid_q;
  assign resp_data  = resp_data_q;
  assign mem_req    = (state_q == ST_FILL);
  assign mem_addr   = fill_addr(ppn_q, wo_q, cnt_q);

  // R3: a hit answers next cycle without touching memory
  assert_hit_no_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_hit |=> (resp_valid && !mem_req));

  // R6: memory request held steady until acknowledged
  assert_mem_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R6: response follows the last fill word
  assert_fill_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_last |=> (resp_valid && !mem_req));

  // R8: waiting for translation produces nothing
  assert_stall_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall_evt |-> (!mem_req && !req_ready && !resp_valid));

  // R10: responses are single-cycle pulses
  assert_resp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  // R10: no acceptance while an access is in flight
  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
endmodule

// File: tb/sim_vipt_cache.sv
module sim_vipt_cache;
  localparam int VA_W = 32, PA_W = 20, PAGE_W = 12, LINE_W = 4, IDX_W = 4;
  localparam int PPN_W = PA_W - PAGE_W;
  localparam int WORDS = 1 << (LINE_W - 2);
  localparam int SETS  = 1 << IDX_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flush = 1'b0, req_valid = 1'b0, tlb_valid = 1'b0, mem_ack = 1'b0;
  logic [VA_W-1:0]  req_vaddr = '0;
  logic [PPN_W-1:0] tlb_ppn = '0;
  logic [31:0]      mem_rdata = '0;
  logic req_ready, resp_valid, mem_req;
  logic [31:0]      resp_data;
  logic [PA_W-1:0]  mem_addr;

  int errors = 0, checks = 0, acks_seen = 0;
  logic [PA_W-LINE_W-1:0] exp_line = '0;

  bit        m_valid [SETS];
  logic [11:0] m_tag [SETS];

  always #4 clk = ~clk;

  vipt_cache #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_W(PAGE_W), .LINE_W(LINE_W), .IDX_W(IDX_W)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_ready(req_ready), .tlb_valid(tlb_valid), .tlb_ppn(tlb_ppn),
    .resp_valid(resp_valid), .resp_data(resp_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] mem_word(input logic [PA_W-1:0] pa);
    return (32'(pa) * 32'h9E37_79B1) ^ 32'h0F1E_2D3C;
  endfunction

  function automatic logic [PA_W-1:0] word_pa(input logic [PPN_W-1:0] ppn, input logic [31:0] va);
    return {ppn, va[11:2], 2'b00};
  endfunction

  function automatic logic [11:0] exp_tag(input logic [PPN_W-1:0] ppn, input logic [31:0] va);
    return {ppn, va[11:8]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Memory model: random-gap acknowledgements, address checks (R2)
  always @(posedge clk) begin
    #2;
    if (!rst_n) begin
      mem_ack = 1'b0;
    end else begin
      if (mem_ack) acks_seen++;
      if (mem_req) begin
        chk(mem_addr[PA_W-1:LINE_W] == exp_line, "R2", "fill line address",
            32'(mem_addr[PA_W-1:LINE_W]), 32'(exp_line));
        chk(mem_addr[1:0] == 2'b00 && 32'(mem_addr[LINE_W-1:2]) == (acks_seen % WORDS),
            "R2", "fill word order", 32'(mem_addr[LINE_W-1:0]), 32'((acks_seen % WORDS) * 4));
      end
      mem_ack   = mem_req && ($urandom_range(0, 2) != 0);
      mem_rdata = mem_word(mem_addr);
    end
  end

  task automatic model_flush();
    for (int i = 0; i < SETS; i++) m_valid[i] = 1'b0;
  endtask

  // One load; called at a negedge, returns at a negedge after the response
  task automatic access(input logic [31:0] va, input logic [PPN_W-1:0] ppn,
                        input int dly, input bit flush_mid, output bit hit_obs);
    int idx, base, n;
    bit exp_hit;
    logic [31:0] exp_d;
    n = 0;
    while (!req_ready && n < 100) begin @(negedge clk); n++; end
    idx     = int'(va[LINE_W+IDX_W-1:LINE_W]);
    exp_hit = m_valid[idx] && (m_tag[idx] == exp_tag(ppn, va));
    exp_d   = mem_word(word_pa(ppn, va));
    exp_line = {ppn, va[11:4]};
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0; req_vaddr = $urandom;
    chk(req_ready == 1'b0, "R10", "ready low while busy", 32'(req_ready), 0);
    for (int d = 0; d < dly; d++) begin
      tlb_ppn = PPN_W'($urandom);
      chk(!resp_valid && !mem_req && !req_ready, "R8", "quiet during tlb stall",
          {29'd0, resp_valid, mem_req, req_ready}, 0);
      @(negedge clk);
    end
    tlb_valid = 1'b1; tlb_ppn = ppn;
    base = acks_seen;
    @(negedge clk);
    tlb_valid = 1'b0; tlb_ppn = PPN_W'($urandom);
    hit_obs = resp_valid;
    if (exp_hit) begin
      chk(resp_valid && !mem_req, "R3", "hit one cycle after translation",
          {30'd0, resp_valid, mem_req}, 32'd2);
      if (resp_valid) chk(resp_data == exp_d, "R4", "hit data", resp_data, exp_d);
    end else begin
      chk(!resp_valid && mem_req, "R4", "miss starts fill", {30'd0, resp_valid, mem_req}, 32'd1);
      if (flush_mid) flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      n = 0;
      while (!resp_valid && n < 100) begin @(negedge clk); n++; end
      chk(acks_seen - base == WORDS, "R6", "words taken before response",
          32'(acks_seen - base), WORDS);
      chk(resp_valid && resp_data == exp_d, "R6", "fill data", resp_data, exp_d);
      m_valid[idx] = 1'b1;
      m_tag[idx]   = exp_tag(ppn, va);
      if (flush_mid) begin
        chk(req_ready == 1'b0, "R9", "ready low with flush pending", 32'(req_ready), 0);
        @(negedge clk);
        chk(req_ready == 1'b1 && !resp_valid, "R9", "ready after deferred flush",
            32'(req_ready), 1);
        model_flush();
        return;
      end
    end
    @(negedge clk);
    chk(!resp_valid, "R10", "single-cycle response", 32'(resp_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit h;
    logic [31:0] va;
    model_flush();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !resp_valid && !mem_req, "R1", "reset outputs",
        {29'd0, req_ready, resp_valid, mem_req}, 32'd4);

    // R1/R7: cold miss, then repeat hit
    access(32'hABCD_E134, 8'h21, 0, 1'b0, h);
    chk(h == 1'b0, "R1", "first access misses", 32'(h), 0);
    access(32'hABCD_E138, 8'h21, 0, 1'b0, h);
    chk(h == 1'b1, "R7", "same line hits after fill", 32'(h), 1);

    // R5: alias through a different virtual page
    access(32'h1234_5134, 8'h21, 1, 1'b0, h);
    chk(h == 1'b1, "R5", "alias hits", 32'(h), 1);

    // R4: same set, other page number -> miss; the old occupant then misses (R7)
    access(32'hABCD_E130, 8'h22, 0, 1'b0, h);
    chk(h == 1'b0, "R4", "tag mismatch misses", 32'(h), 0);
    access(32'hABCD_E134, 8'h21, 0, 1'b0, h);
    chk(h == 1'b0, "R7", "evicted line misses", 32'(h), 0);

    // R4: same page and set, different untranslated bits above the index
    access(32'hABCD_E234, 8'h21, 0, 1'b0, h);
    chk(h == 1'b0, "R4", "upper offset bits in tag", 32'(h), 0);

    // R8: long translation stall then hit
    access(32'hABCD_E230, 8'h21, 5, 1'b0, h);
    chk(h == 1'b1, "R8", "hit after stall", 32'(h), 1);

    // R9: flush while idle
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    model_flush();
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready after idle flush", 32'(req_ready), 1);
    access(32'hABCD_E230, 8'h21, 0, 1'b0, h);
    chk(h == 1'b0, "R9", "flushed line misses", 32'(h), 0);

    // R9: flush during a fill is deferred
    access(32'h0000_0070, 8'h05, 0, 1'b1, h);
    access(32'h0000_0070, 8'h05, 0, 1'b0, h);
    chk(h == 1'b0, "R9", "line filled before deferred flush is gone", 32'(h), 0);

    // Random traffic
    for (int i = 0; i < 400; i++) begin
      va = {$urandom, 12'h000};
      va[11:8] = 4'($urandom_range(0, 1));
      va[7:4]  = 4'($urandom_range(0, 3));
      va[3:2]  = 2'($urandom_range(0, 3));
      access(va, PPN_W'($urandom_range(0, 2)),
             ($urandom_range(0, 5) == 0) ? $urandom_range(1, 3) : 0, 1'b0, h);
      if ($urandom_range(0, 39) == 0) begin
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        model_flush();
        @(negedge clk);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule